// File: doc/BRIEF.md
# Phase-Shifted Triangular Carrier Modulator

This block is the local pulse-width modulator of one converter submodule. An up/down counter running on the local oscillator forms a symmetric triangular carrier that climbs from zero to its full-scale value and falls back. Each submodule in an arm of `N_SUB` units shifts its carrier by its own fraction of a period, set by its index. A synchronization pulse re-aligns the carrier to a commanded position plus that index offset, and it also clears a free-running local time counter.

Reference samples arrive with a time tag. A sample waits in a one-entry shadow register and becomes the active reference only once the local time has reached its tag. If no new sample arrives, the last active reference stays in use for as long as needed. The gate output marks the submodule as inserted whenever the active reference is above the carrier count. The controller has two named states. `ST_WAIT_SYNC` is the state after reset, and the gate is held low in it. `ST_RUN` is entered on the transition "first sync", and the transition "re-sync" keeps the controller in `ST_RUN`.

Top module: `pscar_modulator`

## Requirements
- R1: With no sync pulse, `carrier_cnt` changes by exactly one on every clock. It turns from rising to falling at MAXC = 2^CNT_W − 1 and from falling to rising at 0, so one period is PERIOD = 2·MAXC clocks.
- R2: A clock edge with `sync_pulse` high sets the carrier to phase position p = (`sync_pos` + off) mod PERIOD, where off = floor(`sub_idx`·PERIOD/N_SUB). Position p gives count p while rising when p < MAXC, and count PERIOD − p while falling otherwise. The triangle continues from there. `sync_pos` must be below PERIOD.
- R3: A `sub_idx` value of N_SUB or more gives an offset of 0.
- R4: After reset the controller is in `ST_WAIT_SYNC` and `gate_out` is 0 whatever the reference. The first sync edge moves it to `ST_RUN`. `ST_RUN` is never left, and further syncs keep it there.
- R5: In `ST_RUN`, `gate_out` is 1 exactly when the active reference is greater than `carrier_cnt`. It changes in the same cycle as those registered values.
- R6: The local time is cleared to 0 by a sync edge and otherwise advances by one per clock.
- R7: A sample offered with `ref_valid` high is stored as pending. It becomes the active reference at the first clock edge at which the local time, before that edge, is at least its `ref_tag`. This happens in either state.
- R8: A newer sample overwrites a pending one that has not yet been applied. If a pending sample is applied at the same edge as a new arrival, the old one becomes active and the new one becomes pending.
- R9: With nothing pending, the active reference stays unchanged indefinitely. Nothing is requested when samples stop arriving.
- R10: Reset gives count 0 rising, local time 0, an active reference of 0, nothing pending, and `ST_WAIT_SYNC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_idx | input | IDX_W | Zero-based submodule index within the arm |
| sync_pulse | input | 1 | Re-align carrier and clear local time |
| sync_pos | input | POS_W | Commanded phase position in clocks |
| ref_valid | input | 1 | A reference sample is offered this cycle |
| ref_value | input | CNT_W | Reference level, same range as the carrier |
| ref_tag | input | TIME_W | Local time at which the sample takes effect |
| carrier_cnt | output | CNT_W | Current carrier count |
| gate_out | output | 1 | 1 = submodule inserted, 0 = bypassed |

## Verification
A sync or a count step is visible on `carrier_cnt` one clock after the edge that takes it. A sample offered before edge A can change the active reference at the earliest at the edge after A. It changes at the edge where the local time before that edge first reaches its tag. `gate_out` follows the registered count and reference with no further delay. The bench drives its inputs one nanosecond after a rising edge and advances an arithmetic phase-position and schedule model at each edge. It then compares count and gate just after that edge, on every cycle, across all indices including out-of-range ones and several commanded positions.

// File: rtl/pscar_pkg.sv
package pscar_pkg;
    typedef enum logic [0:0] {
        ST_WAIT_SYNC = 1'b0,
        ST_RUN       = 1'b1
    } mod_state_t;
endpackage

// File: rtl/pscar_carrier.sv
module pscar_carrier #(
    parameter int CNT_W = 16,
    parameter int N_SUB = 5,
    localparam int MAXC   = (2 ** CNT_W) - 1,
    localparam int PERIOD = 2 * MAXC,
    localparam int POS_W  = $clog2(PERIOD),
    localparam int IDX_W  = (N_SUB > 1) ? $clog2(N_SUB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pulse,
    input  logic [POS_W-1:0] sync_pos,
    input  logic [IDX_W-1:0] sub_idx,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP_V = {CNT_W{1'b1}};
    localparam logic [POS_W:0]   PER_P = (POS_W+1)'(PERIOD);
    localparam logic [POS_W:0]   MAX_P = (POS_W+1)'(MAXC);

    logic [POS_W-1:0] offs [N_SUB];
    logic [POS_W-1:0] off_sel;
    logic [POS_W:0]   pos_sum;
    logic [POS_W:0]   pos_wrap;
    logic [CNT_W-1:0] load_cnt;
    logic             load_up;
    logic [CNT_W-1:0] cnt_q;
    logic             up_q;

    // phase offset of each index, one table entry per submodule
    for (genvar gi = 0; gi < N_SUB; gi++) begin : g_off
        assign offs[gi] = POS_W'((gi * PERIOD) / N_SUB);
    end

    always_comb begin
        off_sel = '0;
        for (int i = 0; i < N_SUB; i++) begin
            if (sub_idx == IDX_W'(i)) off_sel = offs[i];
        end
    end

    always_comb begin
        pos_sum  = {1'b0, sync_pos} + {1'b0, off_sel};
        pos_wrap = (pos_sum >= PER_P) ? (pos_sum - PER_P) : pos_sum;
        if (pos_wrap < MAX_P) begin
            load_cnt = CNT_W'(pos_wrap);
            load_up  = 1'b1;
        end else begin
            load_cnt = CNT_W'(PER_P - pos_wrap);
            load_up  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
        end else if (sync_pulse) begin
            cnt_q <= load_cnt;
            up_q  <= load_up;
        end else if (up_q) begin
            if (cnt_q == TOP_V) begin
                cnt_q <= TOP_V - 1'b1;
                up_q  <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            if (cnt_q == '0) begin
                cnt_q <= CNT_W'(1);
                up_q  <= 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign cnt = cnt_q;

    // R1
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_pulse |=> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1));
    // R1
    top_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_pulse && cnt_q == TOP_V) |=> cnt_q == TOP_V - 1'b1);
    // R1
    bottom_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_pulse && cnt_q == '0) |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/pscar_ref_sched.sv
module pscar_ref_sched #(
    parameter int CNT_W  = 16,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_pulse,
    input  logic              ref_valid,
    input  logic [CNT_W-1:0]  ref_value,
    input  logic [TIME_W-1:0] ref_tag,
    output logic [CNT_W-1:0]  act_ref
);
    logic [TIME_W-1:0] time_q;
    logic [TIME_W-1:0] tag_q;
    logic [CNT_W-1:0]  shv_q;
    logic [CNT_W-1:0]  act_q;
    logic              pend_q;
    logic              due;

    assign due = pend_q && (time_q >= tag_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) time_q <= '0;
        else if (sync_pulse) time_q <= '0;
        else time_q <= time_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q  <= '0;
            shv_q  <= '0;
            act_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (due) act_q <= shv_q;
            if (ref_valid) begin
                shv_q  <= ref_value;
                tag_q  <= ref_tag;
                pend_q <= 1'b1;
            end else if (due) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign act_ref = act_q;

    // R9
    hold_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q |=> $stable(act_q));
    // R8
    newest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> pend_q && (shv_q == $past(ref_value)));
    // R7
    not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && time_q < tag_q) |=> act_q == $past(act_q));
endmodule

// File: rtl/pscar_ctrl.sv
module pscar_ctrl
    import pscar_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_pulse,
    input  logic [CNT_W-1:0] act_ref,
    input  logic [CNT_W-1:0] cnt,
    output logic             gate
);
    mod_state_t state_q;
    mod_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT_SYNC;
        else state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_SYNC: if (sync_pulse) state_d = ST_RUN;
            ST_RUN:       state_d = ST_RUN;
            default:      state_d = ST_WAIT_SYNC;
        endcase
    end

    always_comb begin
        gate = 1'b0;
        unique case (state_q)
            ST_WAIT_SYNC: gate = 1'b0;
            ST_RUN:       gate = (act_ref > cnt);
            default:      gate = 1'b0;
        endcase
    end

    // R4
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN |=> state_q == ST_RUN);
    // R4
    first_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_SYNC && !sync_pulse) |=> !gate);
    // R5
    gate_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> act_ref > cnt);
endmodule

// File: rtl/pscar_modulator.sv
module pscar_modulator #(
    parameter int CNT_W  = 16,
    parameter int N_SUB  = 5,
    parameter int TIME_W = 32,
    localparam int MAXC   = (2 ** CNT_W) - 1,
    localparam int PERIOD = 2 * MAXC,
    localparam int POS_W  = $clog2(PERIOD),
    localparam int IDX_W  = (N_SUB > 1) ? $clog2(N_SUB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  sub_idx,
    input  logic              sync_pulse,
    input  logic [POS_W-1:0]  sync_pos,
    input  logic              ref_valid,
    input  logic [CNT_W-1:0]  ref_value,
    input  logic [TIME_W-1:0] ref_tag,
    output logic [CNT_W-1:0]  carrier_cnt,
    output logic              gate_out
);
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] act_w;

    pscar_carrier #(.CNT_W(CNT_W), .N_SUB(N_SUB)) u_carrier (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pulse (sync_pulse),
        .sync_pos   (sync_pos),
        .sub_idx    (sub_idx),
        .cnt        (cnt_w)
    );

    pscar_ref_sched #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pulse (sync_pulse),
        .ref_valid  (ref_valid),
        .ref_value  (ref_value),
        .ref_tag    (ref_tag),
        .act_ref    (act_w)
    );

    pscar_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_pulse (sync_pulse),
        .act_ref    (act_w),
        .cnt        (cnt_w),
        .gate       (gate_out)
    );

    assign carrier_cnt = cnt_w;
endmodule

// File: tb/test_pscar_modulator.sv
`timescale 1ns/1ps
module test_pscar_modulator;
    localparam int CW = 4;
    localparam int NS = 5;
    localparam int TW = 16;
    localparam int MX = 15;
    localparam int PR = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    sub_idx = '0;
    logic          sync_pulse = 1'b0;
    logic [4:0]    sync_pos = '0;
    logic          ref_valid = 1'b0;
    logic [CW-1:0] ref_value = '0;
    logic [TW-1:0] ref_tag = '0;
    logic [CW-1:0] carrier_cnt;
    logic          gate_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cnt_tag = "R1";
    string gate_tag = "R4";

    // bench model state
    int m_pos = 0, m_time = 0, m_act = 0, m_shv = 0, m_tag = 0;
    bit m_pend = 0, m_run = 0;

    always #2.5 clk = ~clk;

    pscar_modulator #(.CNT_W(CW), .N_SUB(NS), .TIME_W(TW)) i_pscar_modulator (
        .clk(clk), .rst_n(rst_n), .sub_idx(sub_idx), .sync_pulse(sync_pulse),
        .sync_pos(sync_pos), .ref_valid(ref_valid), .ref_value(ref_value),
        .ref_tag(ref_tag), .carrier_cnt(carrier_cnt), .gate_out(gate_out)
    );

    function automatic int tri_of(int p);
        return (p < MX) ? p : PR - p;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        int ec;
        int eg;
        ec = tri_of(m_pos);
        eg = (m_run && (m_act > ec)) ? 1 : 0;
        chk(int'(carrier_cnt) == ec, cnt_tag, int'(carrier_cnt), ec);
        chk(int'(gate_out) == eg, gate_tag, int'(gate_out), eg);
    endtask

    // one clock: model update from driven inputs, edge, then compare
    task automatic cyc();
        int off;
        bit due;
        off = (int'(sub_idx) < NS) ? int'(sub_idx) * (PR / NS) : 0;
        due = m_pend && (m_time >= m_tag);
        @(posedge clk);
        #1;
        if (due) m_act = m_shv;
        if (ref_valid) begin
            m_shv = int'(ref_value);
            m_tag = int'(ref_tag);
            m_pend = 1;
        end else if (due) begin
            m_pend = 0;
        end
        if (sync_pulse) begin
            m_pos = (int'(sync_pos) + off) % PR;
            m_time = 0;
            m_run = 1;
        end else begin
            m_pos = (m_pos + 1) % PR;
            m_time = m_time + 1;
        end
        sync_pulse = 1'b0;
        ref_valid = 1'b0;
        check_outputs();
    endtask

    task automatic do_sync(int pos);
        sync_pos = 5'(pos);
        sync_pulse = 1'b1;
        cyc();
    endtask

    task automatic send_ref(int v, int t);
        ref_value = CW'(v);
        ref_tag = TW'(t);
        ref_valid = 1'b1;
        cyc();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #750000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk(carrier_cnt == '0, "R10", int'(carrier_cnt), 0);
        chk(gate_out == 1'b0, "R10", int'(gate_out), 0);
        rst_n = 1'b1;

        // R4: reference applied before any sync, gate must stay low
        cnt_tag = "R1";
        gate_tag = "R4";
        send_ref(15, 3);
        idle(45);
        chk(m_act == 15, "R7", m_act, 15);

        // R2 R3 R5: sweep indices and commanded positions
        gate_tag = "R5";
        for (int k = 0; k < 8; k++) begin
            sub_idx = 3'(k);
            cnt_tag = (k < NS) ? "R2" : "R3";
            for (int s = 0; s < 6; s++) begin
                int sp;
                sp = (s == 0) ? 0 : (s == 1) ? 7 : (s == 2) ? 14 :
                     (s == 3) ? 15 : (s == 4) ? 16 : 29;
                do_sync(sp);
                send_ref((k * 3 + s) % 16, 0);
                idle(31);
            end
        end

        // R7 tag timing after a fresh sync
        sub_idx = 3'd2;
        cnt_tag = "R1";
        gate_tag = "R7";
        do_sync(0);
        send_ref(10, 12);
        idle(40);
        send_ref(4, 55);
        idle(20);

        // R8 overwrite before due, and apply with arrival at same edge
        gate_tag = "R8";
        send_ref(3, 100);
        send_ref(13, 105);
        idle(30);
        send_ref(7, 0);
        send_ref(12, 0);
        idle(35);

        // R9 no more samples: last reference held
        gate_tag = "R9";
        idle(300);
        chk(m_act == 12, "R9", m_act, 12);

        // R6 time cleared by sync: pending tag measured from the new zero
        gate_tag = "R6";
        send_ref(14, 600);
        idle(10);
        do_sync(9);
        idle(620);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule